// File: doc/BRIEF.md
# Control Register Bank with Indirect Write Side Effects

This block holds a small bank of 32-bit control registers. Most offsets only store what is written to them. Two offsets are data registers, and writing one of them also performs a second, indirect write into other storage. Writing the table-data register puts the value into a 64-entry jump table at the index held in the table-index register, and that index then advances by one. Writing the target-data register puts the value into a 256-entry target register file at an offset taken from the low half of the target-address register. That offset then advances by one while the upper half of the register, which holds flag bits, stays as it is.

A sequencer streams a run of words by writing the address register once and then writing the data register repeatedly, one word per cycle. Every indirect write finishes in the cycle of the port write, so the next word may follow on the very next clock. A per-register written vector records which control offsets have been written through the port. A sticky error flag reports an attempt to write past the end of the jump table.

Top module: `cse_regs`

## Requirements
- R1: A port write to control offset k stores the data, so the control read port returns it from the next cycle on, and sets bit k of the written vector. Automatic index advances do not set written bits.
- R2: A port write to the table-data register (offset 5) stores the data into the jump-table entry selected by the table-index register (offset 4), readable on the table read port from the next cycle on.
- R3: After an in-range table-data write, the table-index register holds its previous value plus one.
- R4: A table-data write while the table index is 64 or more changes no table entry and leaves the table index unchanged. It sets the error flag, which then stays set until reset.
- R5: A port write to the target-data register (offset 7) raises the target write strobe in that same cycle, carrying the low 16 bits of the target-address register (offset 6) as the offset and the written data. The target file returns the value at that offset from the next cycle on.
- R6: After every target-data write, the low 16 bits of the target-address register increase by one, wrapping from 0xFFFF to 0x0000. The upper 16 flag bits are kept unchanged.
- R7: A target offset of 256 or more gives no write strobe and changes no target entry. Reading such an offset returns zero, and the offset still advances.
- R8: Data-register writes on consecutive cycles each use the address left by the previous write and advance it exactly once. This holds with table and target writes interleaved.
- R9: Synchronous active-high reset clears every control register, every written bit, the jump table, the target file and the error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write enable |
| ctrl_widx | input | 4 | Control register write offset |
| ctrl_wdata | input | 32 | Control register write data |
| ctrl_ridx | input | 4 | Control register read offset |
| ctrl_rdata | output | 32 | Control register read data |
| ctrl_written | output | 16 | One bit per control register, set by a port write |
| jt_ridx | input | 6 | Jump table read index |
| jt_rdata | output | 32 | Jump table read data |
| jt_err | output | 1 | Sticky out-of-range table write flag |
| tgt_we | output | 1 | Target register file write strobe |
| tgt_woff | output | 16 | Target register file write offset |
| tgt_wdata | output | 32 | Target register file write data |
| tgt_roff | input | 16 | Target register file read offset |
| tgt_rdata | output | 32 | Target register file read data, zero beyond the file |

## Verification
The bench streams data writes back to back, because a design that read a stale address would write two words to one slot and skip an index. It walks the table index across 63 into 64. An off-by-one range test would corrupt entry 0 through truncation, or it would advance the index past the end without raising the error. It sets the target offset to 0xFE and to 0xFFFF with flag bits set, which catches a carry into the flag half, a wrapped strobe at offset 0x100, and a non-zero read beyond the file. A reset in the middle of the run shows whether any storage survives reset.

// File: rtl/cse_pkg.sv
package cse_pkg;
   typedef logic [31:0] word_t;

   localparam int OFS_W = 16;

   // advance the low offset half, keep the flag half
   function automatic word_t step_offset(word_t a);
      return {a[31:OFS_W], a[OFS_W-1:0] + 16'd1};
   endfunction
endpackage

// File: rtl/cse_store.sv
module cse_store
   import cse_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int IDX_W = 6,
   localparam int SEL_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  word_t            wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output word_t            rd_data
);

   if (DEPTH < 1 || DEPTH > (2 ** IDX_W)) begin : g_bad_depth
      $error("cse_store: DEPTH must fit in IDX_W index bits");
   end

   function automatic logic in_range(logic [IDX_W-1:0] idx);
      return ({1'b0, idx} < (IDX_W+1)'(DEPTH));
   endfunction

   word_t mem_q [DEPTH];

   for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
      always_ff @(posedge clk) begin
         if (rst)
            mem_q[gi] <= '0;
         else if (wr_en && wr_idx == IDX_W'(gi))
            mem_q[gi] <= wr_data;
      end
   end

   assign rd_data = in_range(rd_idx) ? mem_q[rd_idx[SEL_W-1:0]] : '0;

   // the caller gates strobes to in-range indices (R4 for the table)
   assert_store_idx_in_range_R7: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> in_range(wr_idx));

endmodule

// File: rtl/cse_ctrl_bank.sv
module cse_ctrl_bank
   import cse_pkg::*;
#(
   parameter int N_REGS = 16,
   parameter int IW     = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic [IW-1:0]     wr_idx,
   input  word_t             wr_data,
   input  logic              up_en,
   input  logic [IW-1:0]     up_idx,
   input  word_t             up_data,
   input  logic [IW-1:0]     rd_idx,
   output word_t             rd_data,
   output word_t             regs_q [N_REGS],
   output logic [N_REGS-1:0] written_q
);

   if (N_REGS < 2 || N_REGS > (2 ** IW)) begin : g_bad_regs
      $error("cse_ctrl_bank: N_REGS must fit in IW offset bits");
   end

   for (genvar gr = 0; gr < N_REGS; gr++) begin : g_reg
      always_ff @(posedge clk) begin
         if (rst) begin
            regs_q[gr]    <= '0;
            written_q[gr] <= 1'b0;
         end else if (wr_en && wr_idx == IW'(gr)) begin
            regs_q[gr]    <= wr_data;
            written_q[gr] <= 1'b1;
         end else if (up_en && up_idx == IW'(gr)) begin
            regs_q[gr]    <= up_data;
         end
      end
   end

   assign rd_data = ({1'b0, rd_idx} < (IW+1)'(N_REGS)) ? regs_q[rd_idx] : '0;

   assert_store_value_R1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> regs_q[$past(wr_idx)] == $past(wr_data));

   assert_written_set_R1: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> written_q[$past(wr_idx)]);

   assert_update_disjoint_R8: assert property (@(posedge clk) disable iff (rst)
      (wr_en && up_en) |-> (wr_idx != up_idx));

endmodule

// File: rtl/cse_side_decode.sv
module cse_side_decode
   import cse_pkg::*;
#(
   parameter int N_REGS      = 16,
   parameter int IW          = 4,
   parameter int JT_DEPTH    = 64,
   parameter int JT_IW       = 6,
   parameter int TGT_DEPTH   = 256,
   parameter int JT_IDX_OFS  = 4,
   parameter int JT_DATA_OFS = 5,
   parameter int TG_ADR_OFS  = 6,
   parameter int TG_DATA_OFS = 7
) (
   input  logic             we,
   input  logic [IW-1:0]    widx,
   input  word_t            jt_base,
   input  word_t            tg_base,
   output logic             jt_we,
   output logic [JT_IW-1:0] jt_widx,
   output logic             jt_oob,
   output logic             tg_we,
   output logic [OFS_W-1:0] tg_woff,
   output logic             up_en,
   output logic [IW-1:0]    up_idx,
   output word_t            up_data
);

   logic jt_hit, tg_hit, jt_in, tg_in;

   assign jt_hit  = we && (widx == IW'(JT_DATA_OFS));
   assign tg_hit  = we && (widx == IW'(TG_DATA_OFS));
   assign jt_in   = jt_base < word_t'(JT_DEPTH);
   assign tg_in   = {1'b0, tg_base[OFS_W-1:0]} < (OFS_W+1)'(TGT_DEPTH);

   assign jt_we   = jt_hit && jt_in;
   assign jt_oob  = jt_hit && !jt_in;
   assign jt_widx = jt_base[JT_IW-1:0];

   assign tg_we   = tg_hit && tg_in;
   assign tg_woff = tg_base[OFS_W-1:0];

   always_comb begin
      up_en   = 1'b0;
      up_idx  = IW'(JT_IDX_OFS);
      up_data = jt_base + 32'd1;
      if (jt_we) begin
         up_en = 1'b1;
      end else if (tg_hit) begin
         up_en   = 1'b1;
         up_idx  = IW'(TG_ADR_OFS);
         up_data = step_offset(tg_base);
      end
   end

endmodule

// File: rtl/cse_regs.sv
module cse_regs
   import cse_pkg::*;
#(
   parameter int N_REGS      = 16,
   parameter int JT_DEPTH    = 64,
   parameter int TGT_DEPTH   = 256,
   parameter int JT_IDX_OFS  = 4,
   parameter int JT_DATA_OFS = 5,
   parameter int TG_ADR_OFS  = 6,
   parameter int TG_DATA_OFS = 7,
   localparam int IW    = $clog2(N_REGS),
   localparam int JT_IW = $clog2(JT_DEPTH)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ctrl_we,
   input  logic [IW-1:0]     ctrl_widx,
   input  logic [31:0]       ctrl_wdata,
   input  logic [IW-1:0]     ctrl_ridx,
   output logic [31:0]       ctrl_rdata,
   output logic [N_REGS-1:0] ctrl_written,
   input  logic [JT_IW-1:0]  jt_ridx,
   output logic [31:0]       jt_rdata,
   output logic              jt_err,
   output logic              tgt_we,
   output logic [15:0]       tgt_woff,
   output logic [31:0]       tgt_wdata,
   input  logic [15:0]       tgt_roff,
   output logic [31:0]       tgt_rdata
);

   if (JT_IDX_OFS == JT_DATA_OFS || TG_ADR_OFS == TG_DATA_OFS ||
       JT_IDX_OFS == TG_ADR_OFS || JT_DATA_OFS == TG_DATA_OFS ||
       JT_IDX_OFS == TG_DATA_OFS || JT_DATA_OFS == TG_ADR_OFS) begin : g_bad_ofs
      $error("cse_regs: special offsets must be distinct");
   end
   if (JT_IDX_OFS >= N_REGS || JT_DATA_OFS >= N_REGS ||
       TG_ADR_OFS >= N_REGS || TG_DATA_OFS >= N_REGS) begin : g_bad_range
      $error("cse_regs: special offsets must lie inside the bank");
   end
   if (TGT_DEPTH < 1 || TGT_DEPTH > (2 ** OFS_W)) begin : g_bad_tgt
      $error("cse_regs: target file depth exceeds the offset field");
   end

   word_t            regs_q [N_REGS];
   word_t            jt_base, tg_base, up_data;
   logic             jt_we, jt_oob, tg_we, up_en;
   logic [JT_IW-1:0] jt_widx;
   logic [OFS_W-1:0] tg_woff;
   logic [IW-1:0]    up_idx;
   logic             err_q;

   cse_ctrl_bank #(.N_REGS(N_REGS), .IW(IW)) u_bank (
      .clk       (clk),
      .rst       (rst),
      .wr_en     (ctrl_we),
      .wr_idx    (ctrl_widx),
      .wr_data   (ctrl_wdata),
      .up_en     (up_en),
      .up_idx    (up_idx),
      .up_data   (up_data),
      .rd_idx    (ctrl_ridx),
      .rd_data   (ctrl_rdata),
      .regs_q    (regs_q),
      .written_q (ctrl_written)
   );

   assign jt_base = regs_q[JT_IDX_OFS];
   assign tg_base = regs_q[TG_ADR_OFS];

   cse_side_decode #(
      .N_REGS(N_REGS), .IW(IW), .JT_DEPTH(JT_DEPTH), .JT_IW(JT_IW),
      .TGT_DEPTH(TGT_DEPTH), .JT_IDX_OFS(JT_IDX_OFS), .JT_DATA_OFS(JT_DATA_OFS),
      .TG_ADR_OFS(TG_ADR_OFS), .TG_DATA_OFS(TG_DATA_OFS)
   ) u_dec (
      .we      (ctrl_we),
      .widx    (ctrl_widx),
      .jt_base (jt_base),
      .tg_base (tg_base),
      .jt_we   (jt_we),
      .jt_widx (jt_widx),
      .jt_oob  (jt_oob),
      .tg_we   (tg_we),
      .tg_woff (tg_woff),
      .up_en   (up_en),
      .up_idx  (up_idx),
      .up_data (up_data)
   );

   cse_store #(.DEPTH(JT_DEPTH), .IDX_W(JT_IW)) u_jtab (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (jt_we),
      .wr_idx  (jt_widx),
      .wr_data (ctrl_wdata),
      .rd_idx  (jt_ridx),
      .rd_data (jt_rdata)
   );

   cse_store #(.DEPTH(TGT_DEPTH), .IDX_W(OFS_W)) u_tfile (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (tg_we),
      .wr_idx  (tg_woff),
      .wr_data (ctrl_wdata),
      .rd_idx  (tgt_roff),
      .rd_data (tgt_rdata)
   );

   always_ff @(posedge clk) begin
      if (rst)
         err_q <= 1'b0;
      else if (jt_oob)
         err_q <= 1'b1;
   end

   assign jt_err    = err_q;
   assign tgt_we    = tg_we;
   assign tgt_woff  = tg_woff;
   assign tgt_wdata = ctrl_wdata;

   assert_tbl_step_R3: assert property (@(posedge clk) disable iff (rst)
      (ctrl_we && ctrl_widx == IW'(JT_DATA_OFS) && jt_base < word_t'(JT_DEPTH))
      |=> regs_q[JT_IDX_OFS] == $past(jt_base) + 32'd1);

   assert_oob_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (ctrl_we && ctrl_widx == IW'(JT_DATA_OFS) && jt_base >= word_t'(JT_DEPTH))
      |=> jt_err && regs_q[JT_IDX_OFS] == $past(jt_base));

   assert_err_sticky_R4: assert property (@(posedge clk) disable iff (rst)
      jt_err |=> jt_err);

   assert_flags_kept_R6: assert property (@(posedge clk) disable iff (rst)
      (ctrl_we && ctrl_widx == IW'(TG_DATA_OFS))
      |=> regs_q[TG_ADR_OFS][31:16] == $past(tg_base[31:16]) &&
          regs_q[TG_ADR_OFS][15:0] == $past(tg_base[15:0]) + 16'd1);

   assert_tgt_range_R7: assert property (@(posedge clk) disable iff (rst)
      tgt_we |-> ({1'b0, tgt_woff} < 17'(TGT_DEPTH)));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> !jt_err && ctrl_written == '0);

endmodule

// File: tb/cse_regs_bench.sv
`timescale 1ns/1ps
module cse_regs_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ctrl_we = 1'b0;
   logic [3:0]  ctrl_widx = '0;
   logic [31:0] ctrl_wdata = '0;
   logic [3:0]  ctrl_ridx = '0;
   logic [31:0] ctrl_rdata;
   logic [15:0] ctrl_written;
   logic [5:0]  jt_ridx = '0;
   logic [31:0] jt_rdata;
   logic        jt_err;
   logic        tgt_we;
   logic [15:0] tgt_woff;
   logic [31:0] tgt_wdata;
   logic [15:0] tgt_roff = '0;
   logic [31:0] tgt_rdata;

   always #4 clk = ~clk;

   cse_regs u_cse_regs (
      .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_widx(ctrl_widx),
      .ctrl_wdata(ctrl_wdata), .ctrl_ridx(ctrl_ridx), .ctrl_rdata(ctrl_rdata),
      .ctrl_written(ctrl_written), .jt_ridx(jt_ridx), .jt_rdata(jt_rdata),
      .jt_err(jt_err), .tgt_we(tgt_we), .tgt_woff(tgt_woff),
      .tgt_wdata(tgt_wdata), .tgt_roff(tgt_roff), .tgt_rdata(tgt_rdata)
   );

   // reference model
   logic [31:0] m_ctrl [16];
   logic [31:0] m_jt   [64];
   logic [31:0] m_tgt  [256];
   logic [15:0] m_wr;
   logic        m_err;
   int checks = 0;
   int errors = 0;
   int ncyc   = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] tgt_exp(input logic [15:0] off);
      return (off < 16'd256) ? m_tgt[off[7:0]] : 32'd0;
   endfunction

   task automatic model_clear();
      for (int i = 0; i < 16; i++) m_ctrl[i] = '0;
      for (int i = 0; i < 64; i++) m_jt[i] = '0;
      for (int i = 0; i < 256; i++) m_tgt[i] = '0;
      m_wr  = '0;
      m_err = 1'b0;
   endtask

   task automatic model_write(input int idx, input logic [31:0] d);
      logic [31:0] a;
      a = (idx == 5) ? m_ctrl[4] : m_ctrl[6];
      m_ctrl[idx] = d;
      m_wr[idx]   = 1'b1;
      if (idx == 5) begin
         if (a < 32'd64) begin
            m_jt[a[5:0]] = d;
            m_ctrl[4] = a + 32'd1;
         end else begin
            m_err = 1'b1;
         end
      end else if (idx == 7) begin
         if (a[15:0] < 16'd256) m_tgt[a[7:0]] = d;
         m_ctrl[6] = {a[31:16], a[15:0] + 16'd1};
      end
   endtask

   // one clock: drive at negedge, compare pre-edge state, update model
   task automatic cyc(input bit we, input int idx, input logic [31:0] d);
      logic [31:0] a;
      bit exp_we;
      ctrl_we    = we;
      ctrl_widx  = idx[3:0];
      ctrl_wdata = d;
      ctrl_ridx  = ncyc[3:0];
      jt_ridx    = m_ctrl[4][5:0] - 6'd1;
      tgt_roff   = m_ctrl[6][15:0] - 16'd1;
      #1;
      chk(ctrl_rdata == m_ctrl[ctrl_ridx], "R1", "ctrl read", ctrl_rdata, m_ctrl[ctrl_ridx]);
      chk(ctrl_written == m_wr, "R1", "written vector", 32'(ctrl_written), 32'(m_wr));
      chk(jt_rdata == m_jt[jt_ridx], "R2", "table read", jt_rdata, m_jt[jt_ridx]);
      chk(jt_err == m_err, "R4", "error flag", 32'(jt_err), 32'(m_err));
      chk(tgt_rdata == tgt_exp(tgt_roff), "R7", "target read", tgt_rdata, tgt_exp(tgt_roff));
      a = m_ctrl[6];
      exp_we = we && idx == 7 && a[15:0] < 16'd256;
      chk(tgt_we == exp_we, "R5", "target strobe", 32'(tgt_we), 32'(exp_we));
      if (exp_we) begin
         chk(tgt_woff == a[15:0], "R5", "target offset", 32'(tgt_woff), 32'(a[15:0]));
         chk(tgt_wdata == d, "R5", "target data", tgt_wdata, d);
      end
      @(posedge clk);
      if (we) model_write(idx, d);
      ncyc++;
      @(negedge clk);
      ctrl_we = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      ctrl_we = 1'b0;
      repeat (2) @(posedge clk);
      model_clear();
      @(negedge clk);
      rst = 1'b0;
   endtask

   // full read-back sweep with the write port idle
   task automatic sweep(input string req);
      ctrl_we = 1'b0;
      for (int i = 0; i < 16; i++) begin
         ctrl_ridx = 4'(i); #1;
         chk(ctrl_rdata == m_ctrl[i], req, "ctrl sweep", ctrl_rdata, m_ctrl[i]);
      end
      for (int i = 0; i < 64; i++) begin
         jt_ridx = 6'(i); #1;
         chk(jt_rdata == m_jt[i], req, "table sweep", jt_rdata, m_jt[i]);
      end
      for (int i = 0; i < 260; i++) begin
         tgt_roff = 16'(i); #1;
         chk(tgt_rdata == tgt_exp(16'(i)), req, "target sweep", tgt_rdata, tgt_exp(16'(i)));
      end
      tgt_roff = 16'hFFFF; #1;
      chk(tgt_rdata == 32'd0, "R7", "target far read", tgt_rdata, 32'd0);
      chk(ctrl_written == m_wr, req, "written sweep", 32'(ctrl_written), 32'(m_wr));
      chk(jt_err == m_err, req, "error sweep", 32'(jt_err), 32'(m_err));
      @(negedge clk);
   endtask

   initial begin
      model_clear();
      do_reset();
      sweep("R9");

      // R1: plain registers
      cyc(1, 0, 32'h1111_0000);
      cyc(1, 1, 32'h2222_0001);
      cyc(1, 15, 32'hF0F0_000F);
      cyc(0, 0, 32'h0);

      // R2 R3 R8: table streaming back to back
      cyc(1, 4, 32'd10);
      cyc(1, 5, 32'hA000_000A);
      cyc(1, 5, 32'hA000_000B);
      cyc(1, 5, 32'hA000_000C);
      cyc(0, 0, 32'h0);
      chk(m_ctrl[4] == 32'd13, "R3", "model index", m_ctrl[4], 32'd13);

      // R4: run off the end of the table
      cyc(1, 4, 32'd62);
      cyc(1, 5, 32'hB000_003E);
      cyc(1, 5, 32'hB000_003F);
      cyc(1, 5, 32'hBAD0_0040);
      cyc(1, 5, 32'hBAD0_0041);
      cyc(0, 0, 32'h0);
      sweep("R4");

      // R5 R6 R8: target streaming with flags
      cyc(1, 6, 32'hABCD_0020);
      for (int i = 0; i < 4; i++) cyc(1, 7, 32'hC000_0000 + 32'(i));
      cyc(0, 0, 32'h0);

      // R7: across the file end
      cyc(1, 6, 32'h5A5A_00FE);
      for (int i = 0; i < 4; i++) cyc(1, 7, 32'hD000_0000 + 32'(i));
      cyc(0, 0, 32'h0);

      // R6: offset wrap keeps flags
      cyc(1, 6, 32'h1234_FFFF);
      cyc(1, 7, 32'hE000_FFFF);
      cyc(1, 7, 32'hE000_0000);
      cyc(0, 0, 32'h0);

      // R8: interleaved table and target writes
      cyc(1, 4, 32'd30);
      cyc(1, 6, 32'h8000_0040);
      for (int i = 0; i < 6; i++) cyc(1, (i % 2 == 0) ? 5 : 7, 32'h7700_0000 + 32'(i));
      cyc(0, 0, 32'h0);
      sweep("R8");

      // R9: reset mid-run
      do_reset();
      sweep("R9");
      cyc(1, 5, 32'h9999_0000);
      cyc(0, 0, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule